// File: doc/BRIEF.md
# SMBus Configuration Register Slave

A two-wire serial slave that exposes a small bank of 8-bit configuration registers to a bus master. A clock tree controller or similar block uses it to hold output enables, stop policies and mode bits. The register contents leave the block as one flat parallel bus. SCL and SDA are oversampled in the fast system clock domain. The block pulls SDA low through an open-drain enable and never holds SCL low.

The command byte that follows the write address picks the access type. With bit 7 set, the access is a single indexed byte and bits 6:0 give the offset. With bit 7 clear, the access is a sequential block that starts at offset 0. In a block write the master sends a count byte before the data. In a block read the slave returns a count byte first. One register mirrors an identification byte from an input pin. The three low bits of another register mirror sampled strap inputs.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the register bytes are 0:FFh, 1:F6h, 2:FFh, 3:00h, 4:07h, 5:00h, 6:18h with bits 2:0 replaced by `strap_i`, 7:`id_i`, 8:44h. Register k is presented on `cfg_o[8k+7:8k]`.
- R2: The slave answers only to the 7-bit address 69h, which gives D2h for a write and D3h for a read. With any other address it acknowledges nothing and leaves SDA released. It then ignores every following byte, including a byte equal to D2h, until the next start, and changes no register.
- R3: A byte write is D2h, a command with bit 7 = 1 and the offset in bits 6:0, and one data byte. The slave acknowledges each byte by pulling SDA low in the ninth clock, and the addressed register takes the data.
- R4: A byte read is D2h, a command with bit 7 = 1, a repeated start and D3h. The slave then returns the addressed register MSB first.
- R5: A block write is D2h, a command 00h, a count byte and then data bytes. The data bytes go to registers 0, 1, 2 and onward in ascending order, and each byte is acknowledged. If a stop follows any complete byte, the bytes already sent stay written, whatever the count byte said.
- R6: A block read is D2h, command 00h, a repeated start and D3h. The slave first returns the count 09h and then registers 0 to 8 in ascending order, MSB first. A master NACK ends the read and the slave releases SDA.
- R7: Register 7 always reads `id_i`, and register 6 bits 2:0 always read `strap_i`. Writes to these bits have no effect.
- R8: Offsets 9 to 127 read as 00h. Writes to them change no register.
- R9: SDA is only ever pulled low, and the pull-down enable only turns on after a falling edge of SCL, so the slave never disturbs a start, a stop or an SCL-high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| strap_i | input | 3 | Sampled strap values shown in register 6 bits 2:0 |
| id_i | input | 8 | Identification byte returned by register 7 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 72 | Register contents, register k at bits 8k+7:8k |

## Verification
The hardest case to reach is a transfer addressed to another device that carries this slave's own write address as a later data byte, followed by a command and data that would be a valid write. The bench opens such a transfer, checks that no byte draws an acknowledge, and then confirms through `cfg_o` that register 0 is unchanged. A second hard case is a block write cut short by a stop before the declared count is reached. The bench checks that exactly the bytes already sent were written and that the next register kept its value.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG = 9,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int ID_IDX = 7,
  parameter int STRAP_IDX = 6,
  parameter int SW = 3,
  parameter logic [8*NREG-1:0] DEFAULTS = 72'h44_00_18_00_07_00_FF_F6_FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SW-1:0]     strap_i,
  input  logic [7:0]        id_i,
  output logic              sda_oe,
  output logic [8*NREG-1:0] cfg_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [6:0] NREG7 = 7'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  logic rise, fall, start, stop;
  st_t st, nx;
  logic ack, blk;
  logic [3:0] bc;
  logic [7:0] sh, tx, rd, first;
  logic [6:0] ptr;
  logic wr_stb;
  logic [7:0] vw [1<<IW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s = scl_p[1];
  assign scl_d = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_d = sda_p[2];
  assign rise  = scl_s & ~scl_d;
  assign fall  = ~scl_s & scl_d;
  assign start = scl_s & scl_d & sda_d & ~sda_s;
  assign stop  = scl_s & scl_d & ~sda_d & sda_s;

  assign rd     = (ptr < NREG7) ? vw[ptr[IW-1:0]] : 8'h00;
  assign first  = blk ? 8'(NREG) : rd;
  assign wr_stb = (st == S_WR) && fall && !ack && (bc == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; nx <= S_IDLE; ack <= 1'b0; blk <= 1'b0;
      bc <= '0; sh <= '0; tx <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; ack <= 1'b0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= S_ADDR; ack <= 1'b0; bc <= '0; sda_oe <= 1'b0;
    end else if (st == S_ADDR || st == S_CMD || st == S_CNT || st == S_WR) begin
      if (rise && !ack && bc != 4'd8) begin
        sh <= {sh[6:0], sda_s};
        bc <= bc + 4'd1;
      end else if (fall && !ack && bc == 4'd8) begin
        ack <= 1'b1;
        case (st)
          S_ADDR:
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              nx <= sh[0] ? S_RD : S_CMD;
            end else st <= S_SKIP;
          S_CMD: begin
            sda_oe <= 1'b1;
            blk <= ~sh[7];
            ptr <= sh[7] ? sh[6:0] : 7'd0;
            nx  <= sh[7] ? S_WR : S_CNT;
          end
          S_CNT: begin
            sda_oe <= 1'b1;
            nx <= S_WR;
          end
          default: begin
            sda_oe <= 1'b1;
            ptr <= ptr + 7'd1;
            nx <= S_WR;
          end
        endcase
      end else if (fall && ack) begin
        ack <= 1'b0;
        bc  <= '0;
        st  <= nx;
        tx  <= first;
        sda_oe <= (nx == S_RD) ? ~first[7] : 1'b0;
        if (nx == S_RD && !blk) ptr <= ptr + 7'd1;
      end
    end else if (st == S_RD) begin
      if (rise && !ack && bc != 4'd8) begin
        bc <= bc + 4'd1;
        tx <= {tx[6:0], 1'b0};
      end else if (rise && ack && sda_s) begin
        st <= S_SKIP;
      end else if (fall && !ack && bc == 4'd8) begin
        ack <= 1'b1;
        sda_oe <= 1'b0;
      end else if (fall && !ack) begin
        sda_oe <= ~tx[7];
      end else if (fall && ack) begin
        ack <= 1'b0;
        bc  <= '0;
        tx  <= rd;
        sda_oe <= ~rd[7];
        ptr <= ptr + 7'd1;
      end
    end

  for (genvar i = 0; i < (1<<IW); i++) begin : g_reg
    if (i >= NREG) begin : g_none
      assign vw[i] = 8'h00;
    end else if (i == ID_IDX) begin : g_id
      assign vw[i] = id_i;
    end else if (i == STRAP_IDX) begin : g_strap
      logic [7:SW] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= DEFAULTS[8*i+SW +: 8-SW];
        else if (wr_stb && ptr == 7'(i)) q <= sh[7:SW];
      assign vw[i] = {q, strap_i};
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= DEFAULTS[8*i +: 8];
        else if (wr_stb && ptr == 7'(i)) q <= sh;
      assign vw[i] = q;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign cfg_o[8*i +: 8] = vw[i];
  end
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk #(
  parameter int CW = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          scl_d,
  input logic [2:0]    st,
  input logic          ack,
  input logic [3:0]    bc,
  input logic [CW-1:0] cfg_o
);
  logic fell;
  assign fell = scl_d & ~scl_s;

  p_oe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(fell));

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |-> !sda_oe);

  p_bit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bc <= 4'd8);

  p_master_ack_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5 && ack) |-> !sda_oe);

  p_reg_write_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_o[CW-1:64], cfg_o[47:0]}) |-> $past(fell && st == 3'd4 && !ack && bc == 4'd8));
endmodule

bind smb_cfg_slave smb_cfg_chk #(.CW(8*NREG)) u_chk (.*);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] id = 8'h08;
  logic sda_oe;
  logic [71:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int n_tot = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [9];

  always #10 clk = ~clk;

  smb_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                    .strap_i(strap), .id_i(id), .sda_oe(sda_oe), .cfg_o(cfg));

  localparam logic [23:0] VEC [8] = '{
    24'h00_A5_A5, 24'h03_3C_3C, 24'h07_55_08, 24'h06_FF_FD,
    24'h09_77_00, 24'h7F_12_00, 24'h08_81_81, 24'h01_00_00};

  task automatic q();
    repeat (8) @(posedge clk);
    #3;
  endtask

  task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] packed_m();
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[8*i +: 8] = m[i];
    return v;
  endfunction

  task automatic b_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wb(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); scl = 1'b0;
    end
    sda_m = 1'b1; q(); scl = 1'b1; q(); ackd = ~sda_line; scl = 1'b0;
  endtask

  task automatic rb(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); scl = 1'b1; q(); b = {b[6:0], sda_line}; scl = 1'b0;
    end
    q(); sda_m = nack; q(); scl = 1'b1; q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d;
    m = '{8'hFF, 8'hF6, 8'hFF, 8'h00, 8'h07, 8'h00, 8'h1D, 8'h08, 8'h44};
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    q();
    chk("R1 reset contents", cfg, packed_m());

    for (int v = 0; v < 8; v++) begin
      logic [7:0] off, wd, ex;
      {off, wd, ex} = VEC[v];
      b_start(); wb(8'hD2, a0); wb(8'h80 | off, a1); wb(wd, a2); b_stop();
      chk("R3 byte write acks", {a0, a1, a2}, 3'b111);
      if (off < 9 && off != 7) m[off] = (off == 6) ? {wd[7:3], strap} : wd;
      b_start(); wb(8'hD2, a0); wb(8'h80 | off, a1); b_start(); wb(8'hD3, a2);
      rb(1'b1, d); b_stop();
      chk("R4 byte read acks", {a0, a1, a2}, 3'b111);
      if (off == 7 || off == 6) chk("R7 read-only bits", d, ex);
      else if (off >= 9) chk("R8 beyond last register", d, ex);
      else chk("R4 byte read data", d, ex);
      chk("R8 R7 register image", cfg, packed_m());
    end

    b_start(); wb(8'hD2, a0); wb(8'h00, a1); wb(8'h03, a2); wb(8'h11, a3);
    chk("R5 block write acks", {a0, a1, a2, a3}, 4'hF);
    wb(8'h22, a0); wb(8'h33, a1); b_stop();
    chk("R5 block data acks", {a0, a1}, 2'b11);
    m[0] = 8'h11; m[1] = 8'h22; m[2] = 8'h33;
    chk("R5 block write image", cfg, packed_m());

    b_start(); wb(8'hD2, a0); wb(8'h00, a1); wb(8'h05, a2); wb(8'h44, a3); wb(8'h55, a0); b_stop();
    m[0] = 8'h44; m[1] = 8'h55;
    chk("R5 block write cut short", cfg, packed_m());

    b_start(); wb(8'hD2, a0); wb(8'h00, a1); b_start(); wb(8'hD3, a2);
    chk("R6 block read acks", {a0, a1, a2}, 3'b111);
    rb(1'b0, d);
    chk("R6 block read count", d, 8'h09);
    for (int i = 0; i < 9; i++) begin
      rb(i == 8, d);
      chk("R6 block read data", d, m[i]);
    end
    b_stop();
    chk("R6 released after nack", sda_oe, 1'b0);

    b_start(); wb(8'hA0, a0); wb(8'hD2, a1); wb(8'h80, a2); wb(8'h5A, a3); b_stop();
    chk("R2 foreign address no ack", {a0, a1, a2, a3}, 4'h0);
    chk("R2 foreign transfer no write", cfg, packed_m());

    strap = 3'b010; id = 8'h3C;
    m[6] = {m[6][7:3], 3'b010}; m[7] = 8'h3C;
    q();
    chk("R7 pins mirrored", cfg, packed_m());
    chk("R9 idle bus released", sda_oe, 1'b0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule